// File: doc/BRIEF.md
# Pointer-Indexed Host Register Interface

This block is a byte-wide I/O-port slave that occupies four consecutive addresses. The host first writes a function code into a pointer. It then reaches that function through a byte port, or through a pair of data bytes for converter values. The pointer stays in place until it is rewritten, so a run of accesses to one function costs one bus cycle each.

The block holds the multiplexer channel number, the user indicator bit and both 12-bit output-converter words. It returns the ready status, an identification constant and the last conversion result. It also emits single-cycle strobes to its neighbours: conversion start, counter register read and write, counter-ready clear, and digital-port read and write. An activity output stays high for a fixed number of clocks after every access, for driving an access lamp.

Top module: `host_win`

## Requirements
- R1: A write at offset 0 loads the 8-bit pointer, which keeps its value until the next offset-0 write. A read at offset 0 returns FFh.
- R2: After reset both ready flags read 1. With pointer 00h, a read at offset 1 returns the conversion flag in bit 0 and the counter flag in bit 1, with bits 7:2 reading 1.
- R3: A conversion-done pulse clears the conversion flag to 0 (active low). A read at offset 3 with pointer 00h sets it back to 1. When both happen in the same cycle, the done pulse wins.
- R4: A write of any value at offset 1 with pointer 00h raises `adc_start_o` in the same cycle as the write.
- R5: With pointer 00h, offset 2 returns result bits 3:0 in bits 7:4 and zeros in bits 3:0. Offset 3 returns result bits 11:4.
- R6: A write at offset 1 with pointer 01h stores data bits 3:0 as the channel number, visible from the next cycle.
- R7: Pointer 02h selects output word A and 03h selects word B. An offset-2 write stages data bits 7:4 as word bits 3:0 and leaves the word unchanged. An offset-3 write loads the word as {data, staged nibble}.
- R8: Offset-1 accesses with pointer 04h–07h raise `ctc_wr_o` or `ctc_rd_o` in the same cycle, with `ctc_sel_o` = pointer bits 1:0. Reads return `ctc_rdata_i`.
- R9: A pulse on `ctc_edge_i` clears the counter flag to 0 and raises `ctc_irq_o`. A write at offset 1 with pointer 08h pulses `ctc_clr_o`, sets the flag back to 1 and drops the interrupt. An edge in the same cycle wins.
- R10: Offset-1 accesses with pointer 09h, 0Ah or 0Bh raise `dio_wr_o` or `dio_rd_o` with `dio_sel_o` = 0, 1 or 2 respectively. Reads at 0Ah and 0Bh return `dio_rdata_i`, and a read at 09h returns FFh.
- R11: Pointer 80h writes data bit 0 to `led_o` (1 = on) and reads back {7'b0, led}. Pointer 81h reads 2Dh.
- R12: Reads of every unassigned pointer/offset pair return FFh. Writes to them change no output and raise no strobe.
- R13: Any read or write at any offset drives `act_o` high from the next cycle for 16 cycles. A new access restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 2 | Offset within the window |
| bus_wr_i | input | 1 | Write cycle, one clock |
| bus_rd_i | input | 1 | Read cycle, one clock |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed function |
| adc_data_i | input | 12 | Last conversion result |
| adc_done_i | input | 1 | Conversion complete pulse |
| adc_start_o | output | 1 | Start-conversion strobe |
| mux_chan_o | output | 4 | Selected input channel |
| dac_a_o | output | 12 | Output word A |
| dac_b_o | output | 12 | Output word B |
| ctc_edge_i | input | 1 | Counter output rising-edge pulse |
| ctc_rdata_i | input | 8 | Counter read data |
| ctc_sel_o | output | 2 | Counter register select |
| ctc_wr_o | output | 1 | Counter write strobe |
| ctc_rd_o | output | 1 | Counter read strobe |
| ctc_clr_o | output | 1 | Counter-ready clear strobe |
| ctc_irq_o | output | 1 | Counter interrupt request |
| dio_rdata_i | input | 8 | Digital port read data |
| dio_sel_o | output | 2 | Digital register select |
| dio_wr_o | output | 1 | Digital port write strobe |
| dio_rd_o | output | 1 | Digital port read strobe |
| led_o | output | 1 | User indicator |
| act_o | output | 1 | Stretched access activity |

## Verification
The assertions assume that a read and a write never occur in the same cycle, and that each bus access lasts one clock. Under that assumption at most one neighbour strobe fires per cycle, and every write or read is followed by the activity output. The stimulus drives one access per cycle, with idle gaps between them. It applies the done and edge pulses on their own and also in the same cycle as the access that sets the flag back, so that both tie-break rules are exercised.

// File: rtl/host_win_pkg.sv
package host_win_pkg;
  typedef enum logic [1:0] {
    OFS_PTR = 2'd0,
    OFS_CTL = 2'd1,
    OFS_LO  = 2'd2,
    OFS_HI  = 2'd3
  } ofs_e;

  localparam logic [7:0] P_ADC     = 8'h00;
  localparam logic [7:0] P_CHAN    = 8'h01;
  localparam logic [7:0] P_DAC_A   = 8'h02;
  localparam logic [7:0] P_CTC_CLR = 8'h08;
  localparam logic [7:0] P_DIO_CFG = 8'h09;
  localparam logic [7:0] P_DIO_LO  = 8'h0A;
  localparam logic [7:0] P_DIO_HI  = 8'h0B;
  localparam logic [7:0] P_LED     = 8'h80;
  localparam logic [7:0] P_ID      = 8'h81;
  localparam logic [7:0] ID_BYTE   = 8'h2D;
  localparam logic [7:0] RD_IDLE   = 8'hFF;
  localparam int unsigned N_DAC    = 2;

  typedef struct packed {
    logic             ptr_we;
    logic             adc_start;
    logic             adc_ack;
    logic             chan_we;
    logic             ctc_wr;
    logic             ctc_rd;
    logic             ctc_clr;
    logic             dio_wr;
    logic             dio_rd;
    logic             led_we;
    logic [N_DAC-1:0] dac_lo_we;
    logic [N_DAC-1:0] dac_hi_we;
  } strb_t;
endpackage

// File: rtl/host_win_decode.sv
module host_win_decode
  import host_win_pkg::*;
(
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] ptr_i,
  output strb_t      strb_o
);
  logic is_ctc, is_dio;

  always_comb begin
    is_ctc = (ptr_i[7:2] == 6'd1);
    is_dio = (ptr_i == P_DIO_CFG) || (ptr_i == P_DIO_LO) || (ptr_i == P_DIO_HI);
    strb_o = '0;
    unique case (ofs_e'(addr_i))
      OFS_PTR: strb_o.ptr_we = wr_i;
      OFS_CTL: begin
        strb_o.adc_start = wr_i && (ptr_i == P_ADC);
        strb_o.chan_we   = wr_i && (ptr_i == P_CHAN);
        strb_o.ctc_wr    = wr_i && is_ctc;
        strb_o.ctc_rd    = rd_i && is_ctc;
        strb_o.ctc_clr   = wr_i && (ptr_i == P_CTC_CLR);
        strb_o.dio_wr    = wr_i && is_dio;
        strb_o.dio_rd    = rd_i && is_dio;
        strb_o.led_we    = wr_i && (ptr_i == P_LED);
      end
      OFS_LO: begin
        for (int k = 0; k < N_DAC; k++)
          strb_o.dac_lo_we[k] = wr_i && (ptr_i == P_DAC_A + 8'(k));
      end
      OFS_HI: begin
        strb_o.adc_ack = rd_i && (ptr_i == P_ADC);
        for (int k = 0; k < N_DAC; k++)
          strb_o.dac_hi_we[k] = wr_i && (ptr_i == P_DAC_A + 8'(k));
      end
    endcase
  end
endmodule

// File: rtl/host_win_rdmux.sv
module host_win_rdmux
  import host_win_pkg::*;
#(
  parameter int unsigned ADC_W = 12
) (
  input  logic [1:0]       addr_i,
  input  logic [7:0]       ptr_i,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic             adc_rdy_n_i,
  input  logic             ctc_rdy_n_i,
  input  logic [7:0]       ctc_rdata_i,
  input  logic [7:0]       dio_rdata_i,
  input  logic             led_i,
  output logic [7:0]       rdata_o
);
  localparam int unsigned LO_W = ADC_W - 8;

  always_comb begin
    rdata_o = RD_IDLE;
    unique case (ofs_e'(addr_i))
      OFS_PTR: rdata_o = RD_IDLE;
      OFS_CTL: begin
        if (ptr_i == P_ADC)                                 rdata_o = {6'h3F, ctc_rdy_n_i, adc_rdy_n_i};
        else if (ptr_i[7:2] == 6'd1)                        rdata_o = ctc_rdata_i;
        else if (ptr_i == P_DIO_LO || ptr_i == P_DIO_HI)    rdata_o = dio_rdata_i;
        else if (ptr_i == P_LED)                            rdata_o = {7'd0, led_i};
        else if (ptr_i == P_ID)                             rdata_o = ID_BYTE;
      end
      OFS_LO: if (ptr_i == P_ADC) rdata_o = {adc_data_i[LO_W-1:0], {(8-LO_W){1'b0}}};
      OFS_HI: if (ptr_i == P_ADC) rdata_o = adc_data_i[ADC_W-1:LO_W];
    endcase
  end
endmodule

// File: rtl/host_win_dac.sv
module host_win_dac #(
  parameter int unsigned DAC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [7:0]       wdata_i,
  output logic [DAC_W-1:0] word_o
);
  localparam int unsigned LO_W = DAC_W - 8;
  logic [LO_W-1:0] stage_q;

  // word only moves on the high byte, so no half-written value is ever visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      word_o  <= '0;
    end else begin
      if (lo_we_i) stage_q <= wdata_i[7:8-LO_W];
      if (hi_we_i) word_o  <= {wdata_i, stage_q};
    end
  end
endmodule

// File: rtl/host_win_stretch.sv
module host_win_stretch #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic act_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (hit_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign act_o = (cnt_q != '0);
endmodule

// File: rtl/host_win.sv
module host_win
  import host_win_pkg::*;
#(
  parameter int unsigned ADC_W      = 12,
  parameter int unsigned DAC_W      = 12,
  parameter int unsigned CHAN_W     = 4,
  parameter int unsigned ACT_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic [ADC_W-1:0]  adc_data_i,
  input  logic              adc_done_i,
  output logic              adc_start_o,
  output logic [CHAN_W-1:0] mux_chan_o,
  output logic [DAC_W-1:0]  dac_a_o,
  output logic [DAC_W-1:0]  dac_b_o,
  input  logic              ctc_edge_i,
  input  logic [7:0]        ctc_rdata_i,
  output logic [1:0]        ctc_sel_o,
  output logic              ctc_wr_o,
  output logic              ctc_rd_o,
  output logic              ctc_clr_o,
  output logic              ctc_irq_o,
  input  logic [7:0]        dio_rdata_i,
  output logic [1:0]        dio_sel_o,
  output logic              dio_wr_o,
  output logic              dio_rd_o,
  output logic              led_o,
  output logic              act_o
);
  strb_t             strb;
  logic [7:0]        ptr_q;
  logic              adc_rdy_nq, ctc_rdy_nq, led_q;
  logic [CHAN_W-1:0] chan_q;
  logic [DAC_W-1:0]  dac_words [N_DAC];

  host_win_decode u_decode (
    .addr_i (bus_addr_i),
    .wr_i   (bus_wr_i),
    .rd_i   (bus_rd_i),
    .ptr_i  (ptr_q),
    .strb_o (strb)
  );

  host_win_rdmux #(.ADC_W(ADC_W)) u_rdmux (
    .addr_i      (bus_addr_i),
    .ptr_i       (ptr_q),
    .adc_data_i  (adc_data_i),
    .adc_rdy_n_i (adc_rdy_nq),
    .ctc_rdy_n_i (ctc_rdy_nq),
    .ctc_rdata_i (ctc_rdata_i),
    .dio_rdata_i (dio_rdata_i),
    .led_i       (led_q),
    .rdata_o     (bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      adc_rdy_nq <= 1'b1;
      ctc_rdy_nq <= 1'b1;
      chan_q     <= '0;
      led_q      <= 1'b0;
    end else begin
      if (strb.ptr_we)   ptr_q  <= bus_wdata_i;
      if (strb.chan_we)  chan_q <= bus_wdata_i[CHAN_W-1:0];
      if (strb.led_we)   led_q  <= bus_wdata_i[0];
      // a new event beats the acknowledge in the same cycle
      if (adc_done_i)        adc_rdy_nq <= 1'b0;
      else if (strb.adc_ack) adc_rdy_nq <= 1'b1;
      if (ctc_edge_i)        ctc_rdy_nq <= 1'b0;
      else if (strb.ctc_clr) ctc_rdy_nq <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_DAC; g++) begin : g_dac
    host_win_dac #(.DAC_W(DAC_W)) u_dac (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lo_we_i (strb.dac_lo_we[g]),
      .hi_we_i (strb.dac_hi_we[g]),
      .wdata_i (bus_wdata_i),
      .word_o  (dac_words[g])
    );
  end

  host_win_stretch #(.CYCLES(ACT_CYCLES)) u_act (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (bus_wr_i || bus_rd_i),
    .act_o  (act_o)
  );

  assign dac_a_o     = dac_words[0];
  assign dac_b_o     = dac_words[1];
  assign mux_chan_o  = chan_q;
  assign led_o       = led_q;
  assign adc_start_o = strb.adc_start;
  assign ctc_sel_o   = ptr_q[1:0];
  assign ctc_wr_o    = strb.ctc_wr;
  assign ctc_rd_o    = strb.ctc_rd;
  assign ctc_clr_o   = strb.ctc_clr;
  assign ctc_irq_o   = ~ctc_rdy_nq;
  assign dio_sel_o   = ptr_q[1:0] - 2'd1;
  assign dio_wr_o    = strb.dio_wr;
  assign dio_rd_o    = strb.dio_rd;
endmodule

// File: rtl/host_win_checker.sv
module host_win_checker #(
  parameter int unsigned CHAN_W = 4,
  parameter int unsigned DAC_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [7:0]        bus_wdata_i,
  input logic [7:0]        ptr_q,
  input logic              adc_done_i,
  input logic              adc_rdy_nq,
  input logic              ctc_edge_i,
  input logic              ctc_irq_o,
  input logic [CHAN_W-1:0] mux_chan_o,
  input logic [DAC_W-1:0]  dac_a_o,
  input logic              adc_start_o,
  input logic              ctc_wr_o,
  input logic              ctc_rd_o,
  input logic              ctc_clr_o,
  input logic              dio_wr_o,
  input logic              dio_rd_o,
  input logic              act_o
);
  a_r1_ptr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i == 2'd0) |=> $stable(ptr_q));

  a_r1_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 2'd0) |=> ptr_q == $past(bus_wdata_i));

  a_r3_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_done_i |=> !adc_rdy_nq);

  a_r4_start_is_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> (bus_wr_i && bus_addr_i == 2'd1));

  a_r6_chan_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 2'd1 && ptr_q == 8'h01) |=> mux_chan_o == $past(bus_wdata_i[CHAN_W-1:0]));

  a_r7_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i == 2'd3 && ptr_q == 8'h02) |=> $stable(dac_a_o));

  a_r9_edge_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctc_edge_i |=> ctc_irq_o);

  a_r12_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({adc_start_o, ctc_wr_o, ctc_rd_o, ctc_clr_o, dio_wr_o, dio_rd_o}));

  a_r13_act_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i || bus_rd_i) |=> act_o);
endmodule

bind host_win host_win_checker #(.CHAN_W(CHAN_W), .DAC_W(DAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wdata_i (bus_wdata_i),
  .ptr_q       (ptr_q),
  .adc_done_i  (adc_done_i),
  .adc_rdy_nq  (adc_rdy_nq),
  .ctc_edge_i  (ctc_edge_i),
  .ctc_irq_o   (ctc_irq_o),
  .mux_chan_o  (mux_chan_o),
  .dac_a_o     (dac_a_o),
  .adc_start_o (adc_start_o),
  .ctc_wr_o    (ctc_wr_o),
  .ctc_rd_o    (ctc_rd_o),
  .ctc_clr_o   (ctc_clr_o),
  .dio_wr_o    (dio_wr_o),
  .dio_rd_o    (dio_rd_o),
  .act_o       (act_o)
);

// File: tb/host_win_bench.sv
module host_win_bench;
  localparam int ACT = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [11:0] adc_data_i = 12'hABC;
  logic        adc_done_i = 1'b0;
  logic        adc_start_o;
  logic [3:0]  mux_chan_o;
  logic [11:0] dac_a_o, dac_b_o;
  logic        ctc_edge_i = 1'b0;
  logic [7:0]  ctc_rdata_i = 8'h3C;
  logic [1:0]  ctc_sel_o;
  logic        ctc_wr_o, ctc_rd_o, ctc_clr_o, ctc_irq_o;
  logic [7:0]  dio_rdata_i = 8'hA5;
  logic [1:0]  dio_sel_o;
  logic        dio_wr_o, dio_rd_o, led_o, act_o;

  host_win u_host_win (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // reference state
  int m_ptr = 0, m_adc_n = 1, m_ctc_n = 1, m_chan = 0, m_led = 0, m_act = 0;
  int m_dac[2] = '{0, 0};
  int m_stage[2] = '{0, 0};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(int a);
    int v = 'hFF;
    case (a)
      1: begin
        if (m_ptr == 0) v = 'hFC | (m_ctc_n << 1) | m_adc_n;
        else if (m_ptr >= 4 && m_ptr <= 7) v = int'(ctc_rdata_i);
        else if (m_ptr == 'h0A || m_ptr == 'h0B) v = int'(dio_rdata_i);
        else if (m_ptr == 'h80) v = m_led;
        else if (m_ptr == 'h81) v = 'h2D;
      end
      2: if (m_ptr == 0) v = (int'(adc_data_i) & 15) << 4;
      3: if (m_ptr == 0) v = int'(adc_data_i) >> 4;
      default: v = 'hFF;
    endcase
    return v;
  endfunction

  task automatic step(int a, bit w, bit r, int d, bit dn, bit ed, string tag);
    bit ctc_hit, dio_hit;
    @(negedge clk_i);
    bus_addr_i = 2'(a); bus_wr_i = w; bus_rd_i = r; bus_wdata_i = 8'(d);
    adc_done_i = dn; ctc_edge_i = ed;
    #1;
    ctc_hit = (a == 1) && m_ptr >= 4 && m_ptr <= 7;
    dio_hit = (a == 1) && (m_ptr == 9 || m_ptr == 'h0A || m_ptr == 'h0B);
    if (r) chk(tag, bus_rdata_o, exp_rd(a));
    chk("R4 adc_start", adc_start_o, w && a == 1 && m_ptr == 0);
    chk("R6 mux_chan", mux_chan_o, m_chan);
    chk("R7 dac_a", dac_a_o, m_dac[0]);
    chk("R7 dac_b", dac_b_o, m_dac[1]);
    chk("R8 ctc_wr", ctc_wr_o, w && ctc_hit);
    chk("R8 ctc_rd", ctc_rd_o, r && ctc_hit);
    if (ctc_hit && (w || r)) chk("R8 ctc_sel", ctc_sel_o, m_ptr & 3);
    chk("R9 ctc_clr", ctc_clr_o, w && a == 1 && m_ptr == 8);
    chk("R9 ctc_irq", ctc_irq_o, !m_ctc_n);
    chk("R10 dio_wr", dio_wr_o, w && dio_hit);
    chk("R10 dio_rd", dio_rd_o, r && dio_hit);
    if (dio_hit && (w || r)) chk("R10 dio_sel", dio_sel_o, m_ptr - 9);
    chk("R11 led", led_o, m_led);
    chk("R13 act", act_o, m_act > 0);
    // model update for the coming edge, old pointer first
    if (w && a == 1) begin
      if (m_ptr == 1) m_chan = d & 15;
      if (m_ptr == 8) m_ctc_n = 1;
      if (m_ptr == 'h80) m_led = d & 1;
    end
    if (ed) m_ctc_n = 0;
    if (r && a == 3 && m_ptr == 0) m_adc_n = 1;
    if (dn) m_adc_n = 0;
    if (w && a == 2 && (m_ptr == 2 || m_ptr == 3)) m_stage[m_ptr-2] = (d >> 4) & 15;
    if (w && a == 3 && (m_ptr == 2 || m_ptr == 3)) m_dac[m_ptr-2] = ((d & 'hFF) << 4) | m_stage[m_ptr-2];
    if (w || r) m_act = ACT; else if (m_act > 0) m_act--;
    if (w && a == 0) m_ptr = d & 'hFF;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "idle");
  endtask

  task automatic wr(int a, int d, string tag);  step(a, 1, 0, d, 0, 0, tag); endtask
  task automatic rd(int a, string tag);         step(a, 0, 1, 0, 0, 0, tag); endtask

  initial begin
    #200_000_0;
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);
    rd(1, "R2 reset status");
    rd(0, "R1 offset0 read");
    // identity and sticky pointer
    wr(0, 'h81, "R1 ptr");
    rd(1, "R11 id");
    rd(1, "R1 sticky id");
    // conversion flag and data
    wr(0, 'h00, "R1 ptr");
    step(0, 0, 0, 0, 1, 0, "R3 done");
    rd(1, "R3 status after done");
    rd(2, "R5 low byte");
    rd(3, "R5 high byte");
    rd(1, "R3 status after ack");
    adc_data_i = 12'h5F3;
    step(0, 0, 0, 0, 1, 0, "R3 done");
    step(3, 0, 1, 0, 1, 0, "R3 tie ack");
    rd(1, "R3 tie status");
    rd(2, "R5 low byte 2");
    rd(3, "R5 high byte 2");
    wr(1, 'h77, "R4 start");
    // channel
    wr(0, 'h01, "R1 ptr");
    wr(1, 'h5A, "R6 chan");
    wr(1, 'hF3, "R6 chan");
    rd(1, "R12 chan read");
    // output words
    wr(0, 'h02, "R1 ptr");
    wr(2, 'h70, "R7 lo A");
    idle(1);
    wr(3, 'h12, "R7 hi A");
    rd(2, "R12 dac lo read");
    wr(0, 'h03, "R1 ptr");
    wr(2, 'hE5, "R7 lo B");
    wr(3, 'hFF, "R7 hi B");
    wr(3, 'h01, "R7 hi B reuse stage");
    // counter pass-through
    for (int p = 4; p <= 7; p++) begin
      wr(0, p, "R1 ptr");
      ctc_rdata_i = 8'(p * 17);
      wr(1, p, "R8 ctc write");
      rd(1, "R8 ctc read");
    end
    // counter flag
    step(0, 0, 0, 0, 0, 1, "R9 edge");
    wr(0, 'h00, "R1 ptr");
    rd(1, "R9 status");
    wr(0, 'h08, "R1 ptr");
    wr(1, 'h00, "R9 clear");
    step(1, 0, 0, 0, 0, 1, "R9 edge");
    step(1, 1, 0, 0, 0, 1, "R9 tie");
    wr(1, 'h00, "R9 clear");
    rd(1, "R12 ptr08 read");
    // digital port
    for (int p = 9; p <= 11; p++) begin
      wr(0, p, "R1 ptr");
      dio_rdata_i = 8'(p * 13);
      wr(1, 'h3C, "R10 dio write");
      rd(1, "R10 dio read");
    end
    // indicator
    wr(0, 'h80, "R1 ptr");
    wr(1, 'hFF, "R11 led on");
    rd(1, "R11 led read");
    wr(1, 'hFE, "R11 led off");
    rd(1, "R11 led read");
    wr(1, 'h01, "R11 led on");
    // unused pointers
    foreach (m_stage[i]) begin end
    for (int k = 0; k < 3; k++) begin
      int p = (k == 0) ? 'h0C : (k == 1) ? 'h7F : 'hC5;
      wr(0, p, "R1 ptr");
      for (int a = 1; a <= 3; a++) begin
        wr(a, 'hA5, "R12 unused write");
        rd(a, "R12 unused read");
      end
    end
    // activity expiry and restart
    idle(ACT + 3);
    rd(0, "R13 restart");
    idle(5);
    rd(0, "R13 restart");
    idle(ACT + 2);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule